// File: doc/BRIEF.md
# Dual-Mode Serial Register Access Slave

This block lets an external host read and write a 128-location byte space over a slow serial link. The space holds 32 clock/control locations and 96 bytes of general RAM. A static mode pin picks one of two bus styles. In the first, a four-wire SPI-style bus has separate input and output data pins, sends bytes most significant bit first, and accepts either idle polarity of the serial clock. In the second, a three-wire bus shares one data line, sends bytes least significant bit first, takes input on the rising clock edge and drives output on the falling edge.

Each transfer lasts for one high period of chip enable. The first byte is a command/address byte: bit 7 chooses write (1) or read (0) and bits 6:0 select the location. Any number of data bytes may follow. The location advances after every byte and wraps inside the region where it started. All serial inputs are synchronised into the system clock domain, and every edge decision is made there. A write-protect bit in the control location blocks all stores. That bit itself can still be changed, so the host can always lift protection.

Top module: `serial_regfile_slave`

## Requirements
- R1: After reset the data output enable is low and every location, including the control location 0Fh, reads 00h.
- R2: Mode pin high selects the SPI-style bus with bytes sent MSB first. Mode pin low selects the three-wire bus with bytes sent LSB first, input sampled on the rising clock edge and output changed on the falling edge. A byte written in one mode reads back with the same value in the other mode.
- R3: In SPI-style mode the clock level present while chip enable is low is taken as the idle level. The edge leaving idle samples input and the edge returning to idle shifts output, so idle-low and idle-high hosts both work.
- R4: The first byte after chip enable rises is the command. Bit 7 = 1 requests a write and bit 7 = 0 a read. Bits 6:0 address the location, so reads use 00h–7Fh and writes use 80h–FFh.
- R5: A byte is stored only after all 8 of its data bits arrive. Dropping chip enable after 1 to 7 bits of a byte discards that byte and leaves the target location unchanged.
- R6: The output enable stays low through the command byte. It rises on the first shift edge after a read command completes, with the addressed byte then shifting out. It returns low once chip enable falls.
- R7: In a burst the location advances after each byte. In the clock region it wraps from 1Fh to 00h (writes: 9Fh to 80h).
- R8: In the RAM region a burst wraps from 7Fh to 20h (writes: FFh to A0h).
- R9: Locations 12h–1Fh always read 00h, and writes to them are dropped.
- R10: While the write-protect bit (bit 6 of location 0Fh) is 1, writes to every location are blocked. This includes the other seven bits of 0Fh.
- R11: The write-protect bit itself stays writable while set, so writing 0Fh with bit 6 = 0 clears protection, and later writes then take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock by at least 8x |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_mode_i | input | 1 | 1 = SPI-style four-wire bus, 0 = three-wire bus |
| ce_i | input | 1 | Chip enable, active high, frames a transfer |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data input (shared line in three-wire mode) |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Output enable for sdo_o; low means high impedance |

## Verification
A table of single-byte write/read-back pairs crosses the two bus modes and both SPI clock polarities. Most entries write in one mode and read in the other, with data that is not bit-palindromic. A bit-order or polarity fault therefore shows up as a reversed or shifted byte and cannot cancel out. Long bursts started just below each region's top tell apart wrapping within the region from plain counting into the next region, and the reserved locations show up as zeros inside the clock burst. Transfers cut short after 5 and 7 bits, and a sequence that sets, tests and clears write protection, separate committing a full byte from a partial one, and blocking the control bits from keeping the protect bit writable.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam logic [ADDR_W-1:0] CLK_TOP  = 7'h1F;
  localparam logic [ADDR_W-1:0] RAM_BASE = 7'h20;
  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

  typedef enum logic {PH_CMD, PH_DATA} phase_e;

  // advance a location and keep it inside its own region
  function automatic logic [ADDR_W-1:0] burst_next(input logic [ADDR_W-1:0] a);
    if (a <= CLK_TOP) return (a == CLK_TOP) ? '0 : a + 1'b1;
    return (a == ADDR_MAX) ? RAM_BASE : a + 1'b1;
  endfunction
endpackage

// File: rtl/srx_front.sv
module srx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_mode,
  input  logic ce_raw,
  input  logic sclk_raw,
  input  logic sdi_raw,
  output logic ce_act,
  output logic strobe,
  output logic shift,
  output logic din
);
  logic [SYNC_STAGES-1:0] ce_sy, sclk_sy, sdi_sy;
  logic [SYNC_STAGES-1:0] ce_sy_d, sclk_sy_d, sdi_sy_d;
  logic sclk_prev, sclk_prev_d, idle_q, idle_d;
  logic sclk_s, toggle;

  assign ce_act = ce_sy[SYNC_STAGES-1];
  assign sclk_s = sclk_sy[SYNC_STAGES-1];
  assign din    = sdi_sy[SYNC_STAGES-1];
  assign toggle = sclk_s ^ sclk_prev;
  assign strobe = ce_act && toggle && (sclk_s != idle_q);
  assign shift  = ce_act && toggle && (sclk_s == idle_q);

  always_comb begin
    ce_sy_d     = {ce_sy[SYNC_STAGES-2:0], ce_raw};
    sclk_sy_d   = {sclk_sy[SYNC_STAGES-2:0], sclk_raw};
    sdi_sy_d    = {sdi_sy[SYNC_STAGES-2:0], sdi_raw};
    sclk_prev_d = sclk_s;
    idle_d      = idle_q;
    if (!ce_act) idle_d = spi_mode ? sclk_s : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_sy     <= '0;
      sclk_sy   <= '0;
      sdi_sy    <= '0;
      sclk_prev <= 1'b0;
      idle_q    <= 1'b0;
    end else begin
      ce_sy     <= ce_sy_d;
      sclk_sy   <= sclk_sy_d;
      sdi_sy    <= sdi_sy_d;
      sclk_prev <= sclk_prev_d;
      idle_q    <= idle_d;
    end
  end

  AST_IDLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_act && $past(ce_act)) |-> $stable(idle_q)); // R3
endmodule

// File: rtl/srx_engine.sv
module srx_engine
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_mode,
  input  logic              ce_act,
  input  logic              strobe,
  input  logic              shift,
  input  logic              din,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  phase_e            phase_q, phase_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_nx;
  logic [BYTE_W-1:0] in_q, in_d, out_q, out_d, byte_in;
  logic              wr_q, wr_d, sdo_q, sdo_d, oe_q, oe_d, last;

  assign byte_in = spi_mode ? {in_q[BYTE_W-2:0], din} : {din, in_q[BYTE_W-1:1]};
  assign last    = strobe && (bit_q == LAST_BIT);
  assign addr_nx = burst_next(addr_q);
  assign rd_addr = (phase_q == PH_CMD) ? byte_in[ADDR_W-1:0] : addr_nx;
  assign wr_en   = last && (phase_q == PH_DATA) && wr_q;
  assign wr_addr = addr_q;
  assign wr_data = byte_in;
  assign sdo     = sdo_q;
  assign sdo_oe  = oe_q;

  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    addr_d  = addr_q;
    in_d    = in_q;
    out_d   = out_q;
    wr_d    = wr_q;
    sdo_d   = sdo_q;
    oe_d    = oe_q;
    if (!ce_act) begin
      phase_d = PH_CMD;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else begin
      if (strobe) begin
        in_d  = byte_in;
        bit_d = bit_q + 1'b1;
        if (last) begin
          if (phase_q == PH_CMD) begin
            addr_d  = byte_in[ADDR_W-1:0];
            wr_d    = byte_in[BYTE_W-1];
            phase_d = PH_DATA;
            if (!byte_in[BYTE_W-1]) out_d = rd_data;
          end else begin
            addr_d = addr_nx;
            if (!wr_q) out_d = rd_data;
          end
        end
      end
      if (shift && (phase_q == PH_DATA) && !wr_q) begin
        sdo_d = spi_mode ? out_q[BYTE_W-1] : out_q[0];
        out_d = spi_mode ? (out_q << 1) : (out_q >> 1);
        oe_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      bit_q   <= '0;
      addr_q  <= '0;
      in_q    <= '0;
      out_q   <= '0;
      wr_q    <= 1'b0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      addr_q  <= addr_d;
      in_q    <= in_d;
      out_q   <= out_d;
      wr_q    <= wr_d;
      sdo_q   <= sdo_d;
      oe_q    <= oe_d;
    end
  end

  AST_HIZ_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_act |=> !oe_q); // R6
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_act |=> (bit_q == '0 && phase_q == PH_CMD)); // R5
  AST_REGION_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (last && phase_q == PH_DATA) |=> ((addr_q <= CLK_TOP) == ($past(addr_q) <= CLK_TOP))); // R7
  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !wr_q); // R4
endmodule

// File: rtl/srx_store.sv
module srx_store
  import srx_pkg::*;
#(
  parameter int DEPTH     = 2 ** ADDR_W,
  parameter int CTRL_ADDR = 15,
  parameter int WP_BIT    = 6,
  parameter int RSV_LO    = 18,
  parameter int RSV_HI    = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  localparam logic [BYTE_W-1:0] WP_MASK = BYTE_W'(1) << WP_BIT;

  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic              wp;

  assign wp      = mem_q[CTRL_ADDR][WP_BIT];
  assign rd_data = mem_q[rd_addr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_loc
    if (i >= RSV_LO && i <= RSV_HI) begin : g_rsv
      assign mem_q[i] = '0;
    end else begin : g_cell
      logic              sel;
      logic [BYTE_W-1:0] cell_q, cell_d;
      assign sel      = wr_en && (wr_addr == ADDR_W'(i));
      assign mem_q[i] = cell_q;
      if (i == CTRL_ADDR) begin : g_ctrl
        always_comb cell_d = wp ? ((cell_q & ~WP_MASK) | (wr_data & WP_MASK)) : wr_data;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   cell_q <= '0;
          else if (sel) cell_q <= cell_d;
        end
      end else begin : g_plain
        always_comb cell_d = wr_data;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)          cell_q <= '0;
          else if (sel && !wp) cell_q <= cell_d;
        end
      end
    end
  end

  AST_WP_BLOCKS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wp) |=> $stable(mem_q[CTRL_ADDR] & ~WP_MASK)); // R10
  AST_WP_SELF_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) |=> (mem_q[CTRL_ADDR][WP_BIT] == $past(wr_data[WP_BIT]))); // R11
endmodule

// File: rtl/serial_regfile_slave.sv
module serial_regfile_slave
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_mode_i,
  input  logic ce_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic              ce_act, strobe, shift, din, wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [BYTE_W-1:0] rd_data, wr_data;

  srx_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
    .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode_i),
    .ce_raw(ce_i), .sclk_raw(sclk_i), .sdi_raw(sdi_i),
    .ce_act(ce_act), .strobe(strobe), .shift(shift), .din(din)
  );

  srx_engine engine_i (
    .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode_i),
    .ce_act(ce_act), .strobe(strobe), .shift(shift), .din(din),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(sdo_o), .sdo_oe(sdo_oe_o)
  );

  srx_store store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/serial_regfile_slave_tb_top.sv
module serial_regfile_slave_tb_top;
  localparam int HALF = 8;
  localparam int NVEC = 6;
  // {write_spi, read_spi, cpol, read address, data}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b0, 8'h25, 8'hB1},
    {1'b1, 1'b0, 1'b1, 8'h03, 8'h3A},
    {1'b0, 1'b1, 1'b0, 8'h40, 8'h83},
    {1'b0, 1'b0, 1'b0, 8'h0A, 8'h5E},
    {1'b1, 1'b0, 1'b0, 8'h11, 8'hC6},
    {1'b0, 1'b1, 1'b1, 8'h7F, 8'h01}
  };

  logic clk, rst_n, spi_mode, ce, sclk, host_sdi;
  logic sdo, sdo_oe;
  logic [7:0] tx_buf [20];
  logic [7:0] rx_buf [20];
  logic [7:0] rd_val;
  logic oe_in_cmd;
  int checks, fails;
  bit done;

  serial_regfile_slave dut_i (
    .clk(clk), .rst_n(rst_n), .spi_mode_i(spi_mode), .ce_i(ce),
    .sclk_i(sclk), .sdi_i(host_sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input bit spi, input bit cpol, input int n, input int abort_bits);
    bit cp;
    cp = spi ? cpol : 1'b0;
    spi_mode = spi;
    sclk = cp;
    repeat (HALF) @(negedge clk);
    ce = 1'b1;
    repeat (HALF) @(negedge clk);
    oe_in_cmd = 1'b0;
    for (int k = 0; k < n + ((abort_bits > 0) ? 1 : 0); k++) begin
      logic [7:0] r;
      int nb;
      r = '0;
      nb = (k < n) ? 8 : abort_bits;
      for (int j = 0; j < nb; j++) begin
        int idx;
        idx = spi ? 7 - j : j;
        host_sdi = tx_buf[k][idx];
        repeat (HALF) @(negedge clk);
        if (k == 0 && sdo_oe) oe_in_cmd = 1'b1;
        r[idx] = sdo_oe ? sdo : 1'b0;
        sclk = ~cp;
        repeat (HALF) @(negedge clk);
        sclk = cp;
      end
      rx_buf[k] = r;
    end
    repeat (HALF) @(negedge clk);
    ce = 1'b0;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic wr1(input bit spi, input bit cpol, input logic [7:0] a, input logic [7:0] d);
    tx_buf[0] = {1'b1, a[6:0]};
    tx_buf[1] = d;
    send(spi, cpol, 2, 0);
  endtask

  task automatic rd1(input bit spi, input bit cpol, input logic [7:0] a);
    tx_buf[0] = {1'b0, a[6:0]};
    tx_buf[1] = 8'h00;
    send(spi, cpol, 2, 0);
    rd_val = rx_buf[1];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; ce = 1'b0; sclk = 1'b0; host_sdi = 1'b0; spi_mode = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(sdo_oe == 1'b0, "R1 oe after reset", {7'b0, sdo_oe}, 8'h00);
    rd1(1'b1, 1'b0, 8'h0F);
    chk(rd_val == 8'h00, "R1 control after reset", rd_val, 8'h00);
    rd1(1'b0, 1'b0, 8'h20);
    chk(rd_val == 8'h00, "R1 ram after reset", rd_val, 8'h00);

    // R2 R3 R4 vector table: cross-mode write then read
    for (int v = 0; v < NVEC; v++) begin
      wr1(VEC[v][18], VEC[v][16], VEC[v][15:8], VEC[v][7:0]);
      rd1(VEC[v][17], VEC[v][16], VEC[v][15:8]);
      chk(rd_val == VEC[v][7:0], "R2 R3 R4 vector readback", rd_val, VEC[v][7:0]);
    end

    // R6 output enable low during command and after deselect
    chk(oe_in_cmd == 1'b0, "R6 oe low during command", {7'b0, oe_in_cmd}, 8'h00);
    chk(sdo_oe == 1'b0, "R6 oe low after ce falls", {7'b0, sdo_oe}, 8'h00);

    // R7 R9 clock burst write wraps 91h..9Fh -> 80h
    tx_buf[0] = 8'h91;
    tx_buf[1] = 8'hAA;
    for (int k = 2; k < 16; k++) tx_buf[k] = 8'hFF;
    tx_buf[16] = 8'h5C;
    send(1'b1, 1'b0, 17, 0);
    tx_buf[0] = 8'h1E;
    for (int k = 1; k < 5; k++) tx_buf[k] = 8'h00;
    send(1'b1, 1'b1, 5, 0);
    chk(rx_buf[1] == 8'h00, "R9 reserved 1Eh reads zero", rx_buf[1], 8'h00);
    chk(rx_buf[2] == 8'h00, "R9 reserved 1Fh reads zero", rx_buf[2], 8'h00);
    chk(rx_buf[3] == 8'h5C, "R7 read wrap 1Fh to 00h", rx_buf[3], 8'h5C);
    chk(rx_buf[4] == 8'h00, "R7 burst continues at 01h", rx_buf[4], 8'h00);
    rd1(1'b0, 1'b0, 8'h11);
    chk(rd_val == 8'hAA, "R7 burst first byte at 11h", rd_val, 8'hAA);

    // R8 RAM burst wrap FEh..FFh -> A0h, read 7Eh..7Fh -> 20h
    tx_buf[0] = 8'hFE; tx_buf[1] = 8'h5A; tx_buf[2] = 8'h6B; tx_buf[3] = 8'h7C;
    send(1'b0, 1'b0, 4, 0);
    tx_buf[0] = 8'h7E;
    for (int k = 1; k < 4; k++) tx_buf[k] = 8'h00;
    send(1'b1, 1'b1, 4, 0);
    chk(rx_buf[1] == 8'h5A, "R8 burst 7Eh", rx_buf[1], 8'h5A);
    chk(rx_buf[2] == 8'h6B, "R8 burst 7Fh", rx_buf[2], 8'h6B);
    chk(rx_buf[3] == 8'h7C, "R8 wrap to 20h", rx_buf[3], 8'h7C);

    // R5 partial bytes are discarded
    wr1(1'b1, 1'b0, 8'h21, 8'h42);
    tx_buf[0] = 8'hA1; tx_buf[1] = 8'hFF;
    send(1'b1, 1'b0, 1, 5);
    rd1(1'b1, 1'b0, 8'h21);
    chk(rd_val == 8'h42, "R5 abort after 5 bits", rd_val, 8'h42);
    send(1'b0, 1'b0, 1, 7);
    rd1(1'b0, 1'b0, 8'h21);
    chk(rd_val == 8'h42, "R5 abort after 7 bits", rd_val, 8'h42);

    // R10 R11 write protect
    wr1(1'b1, 1'b0, 8'h8F, 8'h40);
    wr1(1'b1, 1'b0, 8'hA2, 8'h99);
    rd1(1'b1, 1'b0, 8'h22);
    chk(rd_val == 8'h00, "R10 ram write blocked", rd_val, 8'h00);
    wr1(1'b0, 1'b0, 8'h83, 8'hEE);
    rd1(1'b0, 1'b0, 8'h03);
    chk(rd_val == 8'h3A, "R10 clock write blocked", rd_val, 8'h3A);
    wr1(1'b1, 1'b0, 8'h8F, 8'h47);
    rd1(1'b1, 1'b0, 8'h0F);
    chk(rd_val == 8'h40, "R10 control bits blocked", rd_val, 8'h40);
    wr1(1'b1, 1'b0, 8'h8F, 8'h05);
    rd1(1'b1, 1'b0, 8'h0F);
    chk(rd_val == 8'h00, "R11 protect bit cleared alone", rd_val, 8'h00);
    wr1(1'b1, 1'b0, 8'h8F, 8'h05);
    rd1(1'b1, 1'b0, 8'h0F);
    chk(rd_val == 8'h05, "R11 control writable again", rd_val, 8'h05);
    wr1(1'b1, 1'b0, 8'hA2, 8'h99);
    rd1(1'b1, 1'b0, 8'h22);
    chk(rd_val == 8'h99, "R11 ram writable again", rd_val, 8'h99);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule